// File: doc/BRIEF.md
# AUX Request Engine with Byte Register Port

This block lets a host assemble a single AUX-style channel request through a byte-wide register port, start it, and then collect the outcome. The host writes a 20-bit target address and a 4-bit request code into three address bytes, sets a length byte, and pushes any outgoing payload into a 16-byte write queue. It then sets the launch bit in the control register.

Once launched, the engine presents the request on an abstract link-side interface. It gives a one-cycle start pulse with the address, code and byte count, and then streams the queued payload one byte per cycle. Next it waits for the link to return read bytes and a reply. The reply code and byte count land in one status byte. Received bytes are popped one at a time through a data register. If the link never answers within a configurable number of cycles, the request ends with a timeout result. A keyed write to a channel-clear register discards both queues and the status before the next request is built.

Top module: `aux_req_engine`

## Requirements
- R1: On the cycle after launch, `lnk_start` pulses for exactly one cycle. `lnk_addr` is then {reg 0x7F bits 3:0, reg 0x7E, reg 0x7D}, and `lnk_code` is reg 0x7F bits 7:4.
- R2: While `lnk_start` is high, `lnk_len` equals reg 0x80 bits 3:0 plus one. When bit 7 of reg 0x80 is set, `lnk_len` is zero and bits 3:0 are ignored.
- R3: Each write to reg 0x81 queues one byte, up to 16; further writes are dropped. After the start pulse, the queued bytes leave on `lnk_wdata` one per cycle with `lnk_wvalid` high, oldest first.
- R4: Bytes taken from `lnk_rdata` while `lnk_rvalid` is high and the engine is waiting are returned in arrival order, one per read of reg 0x82, up to 16. A read of 0x82 with nothing queued returns 0x00 and changes nothing.
- R5: Reg 0x83 bit 0 reads 1 from launch (a write with bit 0 set) until the request completes, then reads 0.
- R6: When `lnk_reply_valid` is seen while waiting, reg 0x84 takes bits 7:5 = `lnk_reply_code` (1 native NACK, 2 native defer, 3 ACK, 4 invalid request, 5 I2C NACK, 6 I2C defer). For codes 1, 2, 3, 5 and 6, bits 4:0 = `lnk_reply_count`.
- R7: For result codes 4 and 7, reg 0x84 bits 4:0 read zero.
- R8: With no reply within `TIMEOUT_CYCLES` cycles of waiting, the request completes with reg 0x84 = {3'd7, 5'd0}, and the busy bit clears.
- R9: Writing 0xFF to reg 0x76 empties both queues, zeroes the status and abandons any request in progress. Any other value written there has no effect.
- R10: Regs 0x7D to 0x80 read back their last written values. Every other address, including 0x76 and 0x81, reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe (pops reg 0x82) |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| lnk_start | output | 1 | One-cycle request start pulse |
| lnk_addr | output | 20 | Request address |
| lnk_code | output | 4 | Request code |
| lnk_len | output | 5 | Payload byte count (0 for no payload) |
| lnk_wvalid | output | 1 | Outgoing payload byte valid |
| lnk_wdata | output | 8 | Outgoing payload byte |
| lnk_rvalid | input | 1 | Returned byte valid |
| lnk_rdata | input | 8 | Returned byte |
| lnk_reply_valid | input | 1 | Reply present, ends the request |
| lnk_reply_code | input | 3 | Reply result code |
| lnk_reply_count | input | 5 | Reply byte count |

## Verification
A corrupted queue pointer or count shows up in the first pop of reg 0x82 or in the streamed payload of the next launch. The symptom is a byte out of order, a missing byte, a 17th byte, or a non-zero value from an empty queue. A stuck sequencer state appears as the busy bit failing to clear one cycle after a reply, or as a start pulse wider than one cycle. A wrong timer shows up as a timeout that never arrives or arrives while a reply is still possible. A status latch fault shows up in the first status read after completion, as a wrong code or a non-zero count on invalid or timeout results.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;

    localparam int unsigned QUEUE_DEPTH = 16;

    localparam logic [7:0] OFS_CHCLR = 8'h76;
    localparam logic [7:0] OFS_ADR0  = 8'h7D;
    localparam logic [7:0] OFS_ADR1  = 8'h7E;
    localparam logic [7:0] OFS_ADR2  = 8'h7F;
    localparam logic [7:0] OFS_LEN   = 8'h80;
    localparam logic [7:0] OFS_WPUSH = 8'h81;
    localparam logic [7:0] OFS_RPOP  = 8'h82;
    localparam logic [7:0] OFS_CTRL  = 8'h83;
    localparam logic [7:0] OFS_STAT  = 8'h84;
    localparam logic [7:0] CHCLR_KEY = 8'hFF;

    typedef enum logic [2:0] {
        RES_NONE      = 3'd0,
        RES_NACK      = 3'd1,
        RES_DEFER     = 3'd2,
        RES_ACK       = 3'd3,
        RES_INVALID   = 3'd4,
        RES_I2C_NACK  = 3'd5,
        RES_I2C_DEFER = 3'd6,
        RES_TIMEOUT   = 3'd7
    } result_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_START,
        SQ_SEND,
        SQ_WAIT
    } seq_e;

    typedef struct packed {
        logic [3:0]  code;
        logic [19:0] addr;
        logic [4:0]  len;
    } req_t;

    function automatic logic [4:0] payload_bytes(input logic [7:0] lenreg);
        return lenreg[7] ? 5'd0 : ({1'b0, lenreg[3:0]} + 5'd1);
    endfunction

    function automatic logic count_is_valid(input result_e r);
        return (r == RES_NACK) || (r == RES_DEFER) || (r == RES_ACK) ||
               (r == RES_I2C_NACK) || (r == RES_I2C_DEFER);
    endfunction

endpackage

// File: rtl/aux_byte_fifo.sv
module aux_byte_fifo #(
    parameter int unsigned DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr,
    input  logic                           push,
    input  logic [7:0]                     din,
    input  logic                           pop,
    output logic [7:0]                     dout,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? 8'h00 : mem[rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end
endmodule

// File: rtl/aux_link_seq.sv
module aux_link_seq
    import aux_req_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       abort,
    input  logic       launch,
    input  req_t       req_in,
    input  logic       wf_empty,
    output logic       wf_pop,
    output req_t       req_out,
    output logic       lnk_start,
    output logic       lnk_wvalid,
    input  logic       lnk_rvalid,
    input  logic       lnk_reply_valid,
    input  logic [2:0] lnk_reply_code,
    input  logic [4:0] lnk_reply_count,
    output logic       rf_push,
    output logic       busy,
    output logic       waiting,
    output logic       done,
    output logic [7:0] done_status
);
    localparam int unsigned TW = $clog2(TIMEOUT_CYCLES+1);

    seq_e          state;
    logic [TW-1:0] timer;
    logic          timed_out;
    result_e       rcode;

    assign busy       = (state != SQ_IDLE);
    assign waiting    = (state == SQ_WAIT);
    assign lnk_start  = (state == SQ_START);
    assign lnk_wvalid = (state == SQ_SEND) && !wf_empty;
    assign wf_pop     = lnk_wvalid;
    assign rf_push    = waiting && lnk_rvalid;
    assign rcode      = result_e'(lnk_reply_code);
    assign timed_out  = waiting && !lnk_reply_valid && (timer == TW'(TIMEOUT_CYCLES-1));
    assign done       = waiting && (lnk_reply_valid || timed_out);

    always_comb begin
        if (lnk_reply_valid)
            done_status = {lnk_reply_code, count_is_valid(rcode) ? lnk_reply_count : 5'd0};
        else
            done_status = {RES_TIMEOUT, 5'd0};
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state   <= SQ_IDLE;
            timer   <= '0;
            req_out <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: if (launch) begin
                    req_out <= req_in;
                    state   <= SQ_START;
                end
                SQ_START: state <= SQ_SEND;
                SQ_SEND: if (wf_empty) begin
                    state <= SQ_WAIT;
                    timer <= '0;
                end
                SQ_WAIT: begin
                    if (done) state <= SQ_IDLE;
                    else      timer <= timer + TW'(1);
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/aux_req_engine.sv
module aux_req_engine
    import aux_req_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH     = QUEUE_DEPTH,
    parameter int unsigned TIMEOUT_CYCLES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_we,
    input  logic        reg_re,
    output logic [7:0]  reg_rdata,
    output logic        lnk_start,
    output logic [19:0] lnk_addr,
    output logic [3:0]  lnk_code,
    output logic [4:0]  lnk_len,
    output logic        lnk_wvalid,
    output logic [7:0]  lnk_wdata,
    input  logic        lnk_rvalid,
    input  logic [7:0]  lnk_rdata,
    input  logic        lnk_reply_valid,
    input  logic [2:0]  lnk_reply_code,
    input  logic [4:0]  lnk_reply_count
);
    localparam int unsigned CW = $clog2(FIFO_DEPTH+1);

    logic [7:0]    adr0_q, adr1_q, adr2_q, len_q, status_q;
    logic          chan_clr, launch, busy, waiting, done;
    logic          wf_push, wf_pop, wf_empty;
    logic          rf_push, rf_pop, rf_empty;
    logic [7:0]    rf_dout, done_status;
    logic [CW-1:0] wf_count, rf_count;
    req_t          req_new, req_cur;

    assign chan_clr = reg_we && (reg_addr == OFS_CHCLR) && (reg_wdata == CHCLR_KEY);
    assign launch   = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[0] && !busy && !chan_clr;
    assign wf_push  = reg_we && (reg_addr == OFS_WPUSH);
    assign rf_pop   = reg_re && (reg_addr == OFS_RPOP);

    assign req_new.code = adr2_q[7:4];
    assign req_new.addr = {adr2_q[3:0], adr1_q, adr0_q};
    assign req_new.len  = payload_bytes(len_q);

    assign lnk_addr = req_cur.addr;
    assign lnk_code = req_cur.code;
    assign lnk_len  = req_cur.len;

    always_ff @(posedge clk) begin
        if (rst) begin
            adr0_q   <= '0;
            adr1_q   <= '0;
            adr2_q   <= '0;
            len_q    <= '0;
            status_q <= '0;
        end else begin
            if (reg_we) begin
                unique case (reg_addr)
                    OFS_ADR0: adr0_q <= reg_wdata;
                    OFS_ADR1: adr1_q <= reg_wdata;
                    OFS_ADR2: adr2_q <= reg_wdata;
                    OFS_LEN:  len_q  <= reg_wdata;
                    default: ;
                endcase
            end
            if (chan_clr)  status_q <= '0;
            else if (done) status_q <= done_status;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_ADR0: reg_rdata = adr0_q;
            OFS_ADR1: reg_rdata = adr1_q;
            OFS_ADR2: reg_rdata = adr2_q;
            OFS_LEN:  reg_rdata = len_q;
            OFS_RPOP: reg_rdata = rf_dout;
            OFS_CTRL: reg_rdata = {7'd0, busy};
            OFS_STAT: reg_rdata = status_q;
            default:  reg_rdata = 8'h00;
        endcase
    end

    aux_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_wq (
        .clk(clk), .rst(rst), .clr(chan_clr),
        .push(wf_push), .din(reg_wdata), .pop(wf_pop),
        .dout(lnk_wdata), .empty(wf_empty), .count(wf_count)
    );

    aux_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_rq (
        .clk(clk), .rst(rst), .clr(chan_clr),
        .push(rf_push), .din(lnk_rdata), .pop(rf_pop),
        .dout(rf_dout), .empty(rf_empty), .count(rf_count)
    );

    aux_link_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .abort(chan_clr), .launch(launch),
        .req_in(req_new), .wf_empty(wf_empty), .wf_pop(wf_pop),
        .req_out(req_cur), .lnk_start(lnk_start), .lnk_wvalid(lnk_wvalid),
        .lnk_rvalid(lnk_rvalid), .lnk_reply_valid(lnk_reply_valid),
        .lnk_reply_code(lnk_reply_code), .lnk_reply_count(lnk_reply_count),
        .rf_push(rf_push), .busy(busy), .waiting(waiting), .done(done),
        .done_status(done_status)
    );
endmodule

// File: rtl/aux_req_engine_chk.sv
module aux_req_engine_chk #(
    parameter int unsigned FIFO_DEPTH     = 16,
    parameter int unsigned TIMEOUT_CYCLES = 64
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           busy,
    input logic                           waiting,
    input logic                           chan_clr,
    input logic                           lnk_start,
    input logic                           lnk_reply_valid,
    input logic                           rf_pop,
    input logic                           rf_push,
    input logic [7:0]                     status_q,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] wf_count,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] rf_count
);
    localparam int unsigned TW = $clog2(TIMEOUT_CYCLES+2);
    logic [TW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || !waiting) wait_cnt <= '0;
        else                 wait_cnt <= wait_cnt + TW'(1);
    end

    assert_start_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        lnk_start |=> !lnk_start);

    assert_wq_bound_R3: assert property (@(posedge clk) disable iff (rst)
        wf_count <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (rst)
        (rf_pop && rf_count == '0 && !rf_push && !chan_clr) |=> (rf_count == '0));

    assert_reply_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (waiting && lnk_reply_valid && !chan_clr) |=> !busy);

    assert_count_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (status_q[7:5] == 3'd4 || status_q[7:5] == 3'd7) |-> (status_q[4:0] == 5'd0));

    assert_timeout_bound_R8: assert property (@(posedge clk) disable iff (rst)
        waiting |-> (wait_cnt < TW'(TIMEOUT_CYCLES)));

    assert_chan_clear_R9: assert property (@(posedge clk) disable iff (rst)
        chan_clr |=> (status_q == 8'd0 && wf_count == '0 && rf_count == '0 && !busy));
endmodule

bind aux_req_engine aux_req_engine_chk #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .waiting(waiting), .chan_clr(chan_clr),
    .lnk_start(lnk_start), .lnk_reply_valid(lnk_reply_valid),
    .rf_pop(rf_pop), .rf_push(rf_push), .status_q(status_q),
    .wf_count(wf_count), .rf_count(rf_count)
);

// File: tb/aux_req_engine_bench.sv
module aux_req_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0, reg_wdata = '0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [7:0]  reg_rdata;
    logic        lnk_start, lnk_wvalid;
    logic [19:0] lnk_addr;
    logic [3:0]  lnk_code;
    logic [4:0]  lnk_len;
    logic [7:0]  lnk_wdata;
    logic        lnk_rvalid = 1'b0, lnk_reply_valid = 1'b0;
    logic [7:0]  lnk_rdata = '0;
    logic [2:0]  lnk_reply_code = '0;
    logic [4:0]  lnk_reply_count = '0;

    int n_cmp = 0;
    int n_mis = 0;

    always #2.5 clk = ~clk;

    aux_req_engine u_aux_req_engine (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    function automatic logic [7:0] wpat(input int i, input int seed);
        return 8'((seed * 7 + i * 13 + 1) & 255);
    endfunction

    function automatic logic [7:0] rpat(input int i, input int seed);
        return 8'((seed * 11 + i * 29 + 5) & 255);
    endfunction

    // One complete request: build, launch, capture link side, reply, read back.
    task automatic txn(input string tag, input logic [3:0] code, input logic [19:0] adr,
                       input logic [7:0] lenreg, input int exp_len, input int nwr,
                       input int nrd, input logic [2:0] rc, input logic [4:0] rcnt,
                       input bit reply);
        logic [7:0] d;
        logic [7:0] got [16];
        int nb, nstart;
        logic [19:0] sa; logic [3:0] sc; logic [4:0] sl;
        int exp_nb, exp_nr;
        sa = '0; sc = '0; sl = '0;
        wr(8'h76, 8'hFF);
        wr(8'h7D, adr[7:0]);
        wr(8'h7E, adr[15:8]);
        wr(8'h7F, {code, adr[19:16]});
        wr(8'h80, lenreg);
        for (int i = 0; i < nwr; i++) wr(8'h81, wpat(i, nwr));
        wr(8'h83, 8'h01);
        nb = 0; nstart = 0;
        for (int c = 0; c < 20; c++) begin
            if (lnk_start) begin
                nstart++; sa = lnk_addr; sc = lnk_code; sl = lnk_len;
            end
            if (lnk_wvalid) begin
                if (nb < 16) got[nb] = lnk_wdata;
                nb++;
            end
            @(negedge clk);
        end
        exp_nb = (nwr > 16) ? 16 : nwr;
        chk({tag, " R1 start pulses"}, nstart, 1);
        chk({tag, " R1 addr"}, sa, adr);
        chk({tag, " R1 code"}, sc, code);
        chk({tag, " R2 len"}, sl, exp_len);
        chk({tag, " R3 byte count"}, nb, exp_nb);
        for (int i = 0; i < exp_nb && i < nb; i++) chk({tag, " R3 byte"}, got[i], wpat(i, nwr));
        rd(8'h83, d);
        chk({tag, " R5 busy"}, d, 8'h01);
        if (reply) begin
            for (int i = 0; i < nrd; i++) begin
                lnk_rvalid = 1'b1; lnk_rdata = rpat(i, nrd);
                @(negedge clk);
            end
            lnk_rvalid = 1'b0;
            lnk_reply_valid = 1'b1; lnk_reply_code = rc; lnk_reply_count = rcnt;
            @(negedge clk);
            lnk_reply_valid = 1'b0;
            rd(8'h83, d);
            chk({tag, " R5 idle after reply"}, d, 8'h00);
            rd(8'h84, d);
            if (rc == 3'd4) chk({tag, " R7 status"}, d, {rc, 5'd0});
            else            chk({tag, " R6 status"}, d, {rc, rcnt});
            exp_nr = (nrd > 16) ? 16 : nrd;
            for (int i = 0; i <= exp_nr; i++) begin
                rd(8'h82, d);
                chk({tag, " R4 pop"}, d, (i < exp_nr) ? rpat(i, nrd) : 8'h00);
            end
        end else begin
            repeat (80) @(negedge clk);
            rd(8'h83, d);
            chk({tag, " R8 idle after timeout"}, d, 8'h00);
            rd(8'h84, d);
            chk({tag, " R8 R7 timeout status"}, d, {3'd7, 5'd0});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_mis++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // Reset state
        rd(8'h84, d); chk("R6 reset status", d, 8'h00);
        rd(8'h83, d); chk("R5 reset ctrl", d, 8'h00);
        rd(8'h82, d); chk("R4 reset pop", d, 8'h00);

        // Write sweep over payload lengths, including no-payload and overflow
        for (int n = 0; n <= 17; n++) begin
            logic [7:0] lr;
            int el;
            lr = (n == 0) ? 8'h8A : ((n > 16) ? 8'h0F : 8'(n - 1));
            el = (n == 0) ? 0 : ((n > 16) ? 16 : n);
            txn("wsweep", 4'h8, 20'(n * 20'h0A3C5 + 20'h10000), lr, el, n, 0,
                3'd3, 5'((n > 16) ? 16 : n), 1'b1);
        end

        // Read sweep over returned lengths, including an extra byte past capacity
        for (int n = 0; n <= 17; n++) begin
            txn("rsweep", 4'h9, 20'(20'hFFFFF - n * 20'h01111), 8'h0F, 16, 0, n,
                3'd3, 5'((n > 16) ? 16 : n), 1'b1);
        end

        // Every link reply code
        for (int r = 1; r <= 6; r++) begin
            txn("rcode", 4'(r), 20'h5A5A5, 8'h82, 0, 0, 2, 3'(r), 5'd5, 1'b1);
        end

        // Timeout with no reply
        txn("tmo", 4'h1, 20'h00001, 8'h00, 1, 1, 0, 3'd0, 5'd0, 1'b0);

        // Channel clear keying (R9)
        txn("keep", 4'h9, 20'h12345, 8'h03, 4, 0, 0, 3'd2, 5'd3, 1'b1);
        wr(8'h76, 8'hFE);
        rd(8'h84, d); chk("R9 non-key keeps status", d, {3'd2, 5'd3});
        wr(8'h76, 8'hFF);
        rd(8'h84, d); chk("R9 key clears status", d, 8'h00);
        wr(8'h81, 8'hAB);
        wr(8'h81, 8'hCD);
        wr(8'h76, 8'hFF);
        txn("afterclr", 4'h8, 20'h00100, 8'h80, 0, 0, 0, 3'd3, 5'd0, 1'b1);

        // Register readback and unimplemented addresses (R10)
        wr(8'h7D, 8'h3C); wr(8'h7E, 8'hC3); wr(8'h7F, 8'h96); wr(8'h80, 8'h85);
        rd(8'h7D, d); chk("R10 readback 7D", d, 8'h3C);
        rd(8'h7E, d); chk("R10 readback 7E", d, 8'hC3);
        rd(8'h7F, d); chk("R10 readback 7F", d, 8'h96);
        rd(8'h80, d); chk("R10 readback 80", d, 8'h85);
        rd(8'h76, d); chk("R10 unimpl 76", d, 8'h00);
        rd(8'h81, d); chk("R10 unimpl 81", d, 8'h00);
        rd(8'h00, d); chk("R10 unimpl 00", d, 8'h00);
        rd(8'h85, d); chk("R10 unimpl 85", d, 8'h00);
        rd(8'hFF, d); chk("R10 unimpl FF", d, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule